// File: doc/BRIEF.md
# DMA Channel Control and Condition Selector Register

This block holds the 16-bit control/status word of one DMA channel and three condition selectors. The selectors decide when the descriptor sequencer raises an interrupt, takes a branch or waits. Software reaches the block through a small register port. The control word and every selector are written with mask/value pairs, so a write changes only the bits it selects. The sequencer and the device change the low device-status byte through per-bit set and clear inputs. The sequencer also reports taken branches, transfer activity and faults.

The upper byte holds the channel's run state. Run, pause, flush and wake belong to software. Dead and active are owned by hardware. Bit 8 records a taken branch. Each selector keeps a mask and a value. Its condition output is high while the device-status byte ANDed with the mask equals the value. The outputs are combinational from the stored state, so the sequencer sees a new condition one clock after the status changes. A single `go` output tells the sequencer whether it may advance.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the control word reads 0x0000, every selector reads mask 0 and value 0, all three condition outputs are 1 and `go` is 0.
- R2: A write to address 0 takes its 16-bit mask from write bits 31:16 and its 16-bit value from bits 15:0. Each writable bit whose mask bit is 1 is loaded from the value one clock later. Every other bit keeps its state.
- R3: Bits 11 (dead), 10 (active) and 9 (always 0) ignore software writes.
- R4: `dev_set[i]` forces status bit i to 1 and `dev_clr[i]` forces it to 0, and both override a software write in the same cycle. Set wins over clear.
- R5: A `br_taken` pulse sets bit 8 and overrides a software clear in the same cycle. Software may clear bit 8 on its own.
- R6: When wake (bit 12) reads 1, the next clock clears both wake and pause (bit 14), so wake reads 1 for exactly one cycle.
- R7: A `fault` pulse sets dead (bit 11). Dead then stays set until run (bit 15) is cleared, and it clears on the same clock as run.
- R8: Active (bit 10) reads the `xfer_active` input as sampled on the previous clock.
- R9: A write to address 1, 2 or 3 loads the interrupt, branch or wait selector respectively, with the mask from write bits 15:8 and the value from bits 7:0. A read of that address returns the selector in the same layout.
- R10: Each condition output is 1 exactly when (status byte AND its mask) equals its value.
- R11: `go` is 1 exactly when run is 1 and both pause and dead are 0.
- R12: A read of address 0 returns the control word in bits 15:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 interrupt, 2 branch, 3 wait selector |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for reg_addr |
| dev_set | input | DEV_W | Per-bit hardware set of device status |
| dev_clr | input | DEV_W | Per-bit hardware clear of device status |
| br_taken | input | 1 | Sequencer took a branch |
| xfer_active | input | 1 | Sequencer is moving data |
| fault | input | 1 | Channel error |
| ctrl_word | output | 16 | Current control/status word |
| go | output | 1 | Sequencer may advance |
| cond_int | output | 1 | Interrupt condition |
| cond_br | output | 1 | Branch condition |
| cond_wait | output | 1 | Wait condition |

## Verification
The bench builds the block with the default device-status width of eight bits. At that width the selector mask and value fill write bits 15:8 and 7:0 exactly, so read-back checks every selector bit. The full status byte can be driven by both software and hardware. All the stimulus also fits in the byte-wide selectors, so every condition output can be steered true and false by moving the status byte alone.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
    localparam int CW      = 16;
    localparam int RUN_B   = 15;
    localparam int PAUSE_B = 14;
    localparam int FLUSH_B = 13;
    localparam int WAKE_B  = 12;
    localparam int DEAD_B  = 11;
    localparam int ACT_B   = 10;
    localparam int BRK_B   = 8;
    localparam int NSEL    = 3;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_INT  = 2'd1,
        A_BR   = 2'd2,
        A_WAIT = 2'd3
    } addr_e;
endpackage

// File: rtl/chanctl_sel.sv
module chanctl_sel #(
    parameter int DEV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [2*DEV_W-1:0] wdata,
    input  logic [DEV_W-1:0]   dev,
    output logic               cond,
    output logic [2*DEV_W-1:0] sel_word
);
    typedef struct packed {
        logic [DEV_W-1:0] mask;
        logic [DEV_W-1:0] val;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr) begin
            sel_d.mask = wdata[2*DEV_W-1:DEV_W];
            sel_d.val  = wdata[DEV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign cond     = ((dev & sel_q.mask) == sel_q.val);
    assign sel_word = {sel_q.mask, sel_q.val};

    // R9
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (sel_q.mask == $past(wdata[2*DEV_W-1:DEV_W])) && (sel_q.val == $past(wdata[DEV_W-1:0])));
endmodule

// File: rtl/chanctl_core.sv
module chanctl_core
    import chanctl_pkg::*;
#(
    parameter int DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CW-1:0]    wmask,
    input  logic [CW-1:0]    wval,
    input  logic [DEV_W-1:0] dev_set,
    input  logic [DEV_W-1:0] dev_clr,
    input  logic             br_taken,
    input  logic             xfer_active,
    input  logic             fault,
    output logic [CW-1:0]    ctrl_word,
    output logic [DEV_W-1:0] dev_stat,
    output logic             go
);
    typedef struct packed {
        logic             run;
        logic             pause;
        logic             flush;
        logic             wake;
        logic             dead;
        logic             active;
        logic             brk;
        logic [DEV_W-1:0] dev;
    } st_t;

    st_t st_d, st_q;
    logic [DEV_W-1:0] dev_sw;

    function automatic logic pick(input logic old, input logic en, input logic m, input logic v);
        return (en && m) ? v : old;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.run   = pick(st_q.run,   wr, wmask[RUN_B],   wval[RUN_B]);
        st_d.pause = pick(st_q.pause, wr, wmask[PAUSE_B], wval[PAUSE_B]);
        st_d.flush = pick(st_q.flush, wr, wmask[FLUSH_B], wval[FLUSH_B]);
        st_d.brk   = pick(st_q.brk,   wr, wmask[BRK_B],   wval[BRK_B]) | br_taken;
        if (st_q.wake) begin
            st_d.wake  = 1'b0;
            st_d.pause = 1'b0;
        end else begin
            st_d.wake  = pick(1'b0, wr, wmask[WAKE_B], wval[WAKE_B]);
        end
        st_d.dead   = fault | (st_q.dead & st_d.run);
        st_d.active = xfer_active;
        dev_sw = wr ? ((st_q.dev & ~wmask[DEV_W-1:0]) | (wval[DEV_W-1:0] & wmask[DEV_W-1:0]))
                    : st_q.dev;
        st_d.dev = (dev_sw & ~dev_clr) | dev_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[RUN_B]   = st_q.run;
        ctrl_word[PAUSE_B] = st_q.pause;
        ctrl_word[FLUSH_B] = st_q.flush;
        ctrl_word[WAKE_B]  = st_q.wake;
        ctrl_word[DEAD_B]  = st_q.dead;
        ctrl_word[ACT_B]   = st_q.active;
        ctrl_word[BRK_B]   = st_q.brk;
        ctrl_word[DEV_W-1:0] = st_q.dev;
    end

    assign dev_stat = st_q.dev;
    assign go       = st_q.run & ~st_q.pause & ~st_q.dead;

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && wmask[RUN_B]) |=> $stable(st_q.run));
    // R4
    dev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_set != '0) |=> ((st_q.dev & $past(dev_set)) == $past(dev_set)));
    // R5
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> st_q.brk);
    // R6
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |=> (!st_q.wake && !st_q.pause));
    // R7
    dead_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> st_q.dead);
    // R8
    active_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |=> st_q.active);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import chanctl_pkg::*;
#(
    parameter int DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [DEV_W-1:0] dev_set,
    input  logic [DEV_W-1:0] dev_clr,
    input  logic             br_taken,
    input  logic             xfer_active,
    input  logic             fault,
    output logic [CW-1:0]    ctrl_word,
    output logic             go,
    output logic             cond_int,
    output logic             cond_br,
    output logic             cond_wait
);
    localparam int SW = 2 * DEV_W;

    logic [DEV_W-1:0] dev_stat;
    logic [SW-1:0]    sel_word [NSEL];
    logic [NSEL-1:0]  cond;
    logic             ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

    chanctl_core #(.DEV_W(DEV_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctrl_wr),
        .wmask       (reg_wdata[31:16]),
        .wval        (reg_wdata[15:0]),
        .dev_set     (dev_set),
        .dev_clr     (dev_clr),
        .br_taken    (br_taken),
        .xfer_active (xfer_active),
        .fault       (fault),
        .ctrl_word   (ctrl_word),
        .dev_stat    (dev_stat),
        .go          (go)
    );

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        logic sel_wr;
        assign sel_wr = reg_wr && (reg_addr == 2'(g + 1));
        chanctl_sel #(.DEV_W(DEV_W)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (sel_wr),
            .wdata    (reg_wdata[SW-1:0]),
            .dev      (dev_stat),
            .cond     (cond[g]),
            .sel_word (sel_word[g])
        );
    end

    assign cond_int  = cond[0];
    assign cond_br   = cond[1];
    assign cond_wait = cond[2];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata[CW-1:0] = ctrl_word;
            A_INT:   reg_rdata[SW-1:0] = sel_word[0];
            A_BR:    reg_rdata[SW-1:0] = sel_word[1];
            default: reg_rdata[SW-1:0] = sel_word[2];
        endcase
    end
endmodule

// File: tb/dma_chan_ctl_test.sv
`timescale 1ns/1ps
module dma_chan_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  dev_set = '0;
    logic [7:0]  dev_clr = '0;
    logic        br_taken = 1'b0;
    logic        xfer_active = 1'b0;
    logic        fault = 1'b0;
    logic [15:0] ctrl_word;
    logic        go, cond_int, cond_br, cond_wait;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dma_chan_ctl #(.DEV_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_set(dev_set),
        .dev_clr(dev_clr), .br_taken(br_taken), .xfer_active(xfer_active),
        .fault(fault), .ctrl_word(ctrl_word), .go(go), .cond_int(cond_int),
        .cond_br(cond_br), .cond_wait(cond_wait)
    );

    // {mask, value, expected control word} for address-0 writes, in sequence
    localparam logic [47:0] VEC [0:6] = '{
        {16'hEFFF, 16'hFFFF, 16'hE1FF},
        {16'h0003, 16'h0000, 16'hE1FC},
        {16'h4000, 16'h0000, 16'hA1FC},
        {16'h00F0, 16'h00A5, 16'hA1AC},
        {16'h0000, 16'hFFFF, 16'hA1AC},
        {16'h8100, 16'h0000, 16'h20AC},
        {16'hFFFF, 16'h0000, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(20.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", {16'h0, ctrl_word}, 32'h0);
        chk("R1 conds/go", {28'h0, cond_int, cond_br, cond_wait, go}, 32'hE);
        reg_addr = 2'd3; #1;
        chk("R1 wait selector", reg_rdata, 32'h0);

        // R2 R3 R12 masked control writes from the table
        for (int i = 0; i < 7; i++) begin
            wr_reg(2'd0, {VEC[i][47:32], VEC[i][31:16]});
            chk("R2 table ctrl", {16'h0, ctrl_word}, {16'h0, VEC[i][15:0]});
            reg_addr = 2'd0; #1;
            chk("R12 read ctrl", reg_rdata, {16'h0, VEC[i][15:0]});
        end

        // R9 R10 selectors
        wr_reg(2'd1, 32'h0000_0F05);
        reg_addr = 2'd1; #1;
        chk("R9 int readback", reg_rdata, 32'h0000_0F05);
        chk("R10 int false", {31'h0, cond_int}, 32'h0);
        wr_reg(2'd0, 32'h00FF_0035);
        chk("R10 int true", {31'h0, cond_int}, 32'h1);
        wr_reg(2'd2, 32'h0000_F030);
        wr_reg(2'd3, 32'h0000_FF00);
        reg_addr = 2'd3; #1;
        chk("R9 wait readback", reg_rdata, 32'h0000_FF00);
        chk("R10 br/wait", {30'h0, cond_br, cond_wait}, 32'h2);

        // R4 hardware beats software
        dev_set = 8'h40;
        wr_reg(2'd0, 32'h00FF_0000);
        dev_set = 8'h00;
        chk("R4 set over sw", {16'h0, ctrl_word}, 32'h0040);
        dev_clr = 8'h81;
        wr_reg(2'd0, 32'h00FF_00FF);
        dev_clr = 8'h00;
        chk("R4 clr over sw", {16'h0, ctrl_word}, 32'h007E);
        dev_set = 8'h01; idle(); dev_set = 8'h00;
        chk("R4 hw set alone", {16'h0, ctrl_word}, 32'h007F);

        // R5 branch flag
        br_taken = 1'b1;
        wr_reg(2'd0, 32'h0100_0000);
        br_taken = 1'b0;
        chk("R5 brk over sw clear", {16'h0, ctrl_word}, 32'h017F);
        wr_reg(2'd0, 32'h0100_0000);
        chk("R5 sw clear", {16'h0, ctrl_word}, 32'h007F);

        // R6 R11 pause and wake
        wr_reg(2'd0, 32'hC000_C000);
        chk("R11 paused go", {31'h0, go}, 32'h0);
        wr_reg(2'd0, 32'h1000_1000);
        chk("R6 wake set", {16'h0, ctrl_word}, 32'hD07F);
        idle();
        chk("R6 wake cleared", {16'h0, ctrl_word}, 32'h807F);
        chk("R11 running go", {31'h0, go}, 32'h1);

        // R7 dead
        fault = 1'b1; idle(); fault = 1'b0;
        chk("R7 dead set", {16'h0, ctrl_word}, 32'h887F);
        chk("R11 dead go", {31'h0, go}, 32'h0);
        repeat (3) idle();
        chk("R7 dead held", {16'h0, ctrl_word}, 32'h887F);
        wr_reg(2'd0, 32'h0800_0000);
        chk("R3 dead not writable", {16'h0, ctrl_word}, 32'h887F);
        wr_reg(2'd0, 32'h8000_0000);
        chk("R7 dead cleared with run", {16'h0, ctrl_word}, 32'h007F);

        // R8 active
        xfer_active = 1'b1; idle();
        chk("R8 active set", {16'h0, ctrl_word}, 32'h047F);
        wr_reg(2'd0, 32'h0400_0000);
        chk("R3 active not writable", {16'h0, ctrl_word}, 32'h047F);
        xfer_active = 1'b0; idle();
        chk("R8 active clear", {16'h0, ctrl_word}, 32'h007F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule